// File: doc/BRIEF.md
# Programmable LCD sync timing generator

The block drives the timing side of a parallel RGB panel from the pixel clock. It makes horizontal sync, vertical sync, a data-enable strobe and the x/y position of the current pixel. It also makes a request strobe that tells an upstream frame-buffer reader to present the next pixel. A small write-only register bank holds the timing for each axis: the total period, the sync pulse width, where the active area begins and how large it is. The bank also holds a run bit, a data-enable polarity bit and an active-mode field.

Timing and control writes are staged. The generator copies them into its working set only while it is stopped or at the last pixel of a frame, so a frame never mixes two timings. The run bit is the one exception and acts at once. In active mode 2, the first frame after start is sent as black. During that frame the block asserts `blank_o` in place of the pixel request across the active area.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, and whenever the run bit is 0, the outputs are idle: `hsync_o`, `vsync_o`, `req_o` and `blank_o` are low, `x_o` and `y_o` are 0, and `de_o` sits at its inactive level.
- R2: While running, each line lasts horizontal total + 1 clocks (address 0). `hsync_o` is high on horizontal counts 0 through sync width − 1 (address 1).
- R3: Each frame lasts vertical total + 1 lines (address 4). `vsync_o` is high on lines 0 through sync width − 1 (address 5).
- R4: The active area covers horizontal counts start (address 2) through start + size (address 3), and lines start (address 6) through start + size (address 7). Sizes hold the count minus one.
- R5: Bit 2 of the port word (address 9) selects the polarity of `de_o`. When it is 1, `de_o` is high inside the active area. When it is 0, `de_o` is low inside the active area and high everywhere else. The reset value is 1.
- R6: Inside the active area, `x_o` and `y_o` give the offset from the active start on each axis. Outside it, both are 0.
- R7: `req_o` is high on every active pixel of every frame that is not blanked.
- R8: When the mode field (address 10, bits 1:0) holds 2, the first frame after start is blanked: `blank_o` is high and `req_o` is low on its active pixels. Later frames are normal. Any other mode value never blanks.
- R9: Writing 1 to bit 0 of address 8 starts the generator. The first clock after the write is pixel (0,0). Writing 0 returns the outputs to idle on the clock after the write.
- R10: Timing, polarity and mode writes made while running have no effect until the next frame begins. Writes made while stopped apply to the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pixel clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cfg_we_i | input | 1 | register write strobe |
| cfg_addr_i | input | CFG_AW | register address |
| cfg_wdata_i | input | CFG_DW | register write data |
| hsync_o | output | 1 | horizontal sync, active high |
| vsync_o | output | 1 | vertical sync, active high |
| de_o | output | 1 | data enable, polarity set by the port word |
| x_o | output | CNT_W | column within the active area |
| y_o | output | CNT_W | line within the active area |
| req_o | output | 1 | pixel data request to the frame-buffer reader |
| blank_o | output | 1 | active pixel forced to black |

## Verification
The assertions assume the timing fields are self-consistent. Sync widths are at most the totals, and each active window ends no later than its total. Under that assumption the counters never pass their totals and every window falls inside one period. They also assume that writes arrive only as single-cycle strobes. The stimulus uses only small consistent timing sets and always programs a full set. It changes the timing of a running generator only in the middle of a frame, which is how the boundary hand-over is exercised.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int CNT_W = 12;

  typedef struct packed {
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] sync_w;
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] size;
  } axis_cfg_t;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_RSVD   = 2'd1,
    MODE_BLACK1 = 2'd2,
    MODE_RSVD3  = 2'd3
  } act_mode_e;

  // register addresses
  localparam int A_H_BASE = 0;
  localparam int A_V_BASE = 4;
  localparam int A_RUN    = 8;
  localparam int A_PORT   = 9;
  localparam int A_MODE   = 10;
  localparam int POL_BIT  = 2;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int CFG_AW = 4,
  parameter int CFG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  input  logic              load_i,
  output logic              run_o,
  output axis_cfg_t         cfg_o [2],
  output logic              pol_o,
  output act_mode_e         mode_o
);
  axis_cfg_t stg_q [2];
  axis_cfg_t act_q [2];
  logic      stg_pol_q, act_pol_q, run_q;
  act_mode_e stg_mode_q, act_mode_q;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    localparam int BASE = (g == 0) ? A_H_BASE : A_V_BASE;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        if (we_i) begin
          case (int'(addr_i))
            BASE + 0: stg_q[g].total  <= wdata_i[CNT_W-1:0];
            BASE + 1: stg_q[g].sync_w <= wdata_i[CNT_W-1:0];
            BASE + 2: stg_q[g].start  <= wdata_i[CNT_W-1:0];
            BASE + 3: stg_q[g].size   <= wdata_i[CNT_W-1:0];
            default: ;
          endcase
        end
        if (load_i) act_q[g] <= stg_q[g];
      end
    end
    assign cfg_o[g] = act_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      stg_pol_q  <= 1'b1;
      act_pol_q  <= 1'b1;
      stg_mode_q <= MODE_NORMAL;
      act_mode_q <= MODE_NORMAL;
    end else begin
      if (we_i) begin
        case (int'(addr_i))
          A_RUN:  run_q      <= wdata_i[0];
          A_PORT: stg_pol_q  <= wdata_i[POL_BIT];
          A_MODE: stg_mode_q <= act_mode_e'(wdata_i[1:0]);
          default: ;
        endcase
      end
      if (load_i) begin
        act_pol_q  <= stg_pol_q;
        act_mode_q <= stg_mode_q;
      end
    end
  end

  assign run_o  = run_q;
  assign pol_o  = act_pol_q;
  assign mode_o = act_mode_q;

  // R10
  mid_frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !load_i) |=> ($stable(act_q[0]) && $stable(act_q[1]) &&
                            $stable(act_pol_q) && $stable(act_mode_q)));
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
  import lcd_tg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  axis_cfg_t        cfg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             sync_o,
  output logic             act_o,
  output logic [CNT_W-1:0] pos_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   act_end;

  assign wrap_o = en_i && (cnt_q == cfg_i.total);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign act_end = {1'b0, cfg_i.start} + {1'b0, cfg_i.size};
  assign sync_o  = cnt_q < cfg_i.sync_w;
  assign act_o   = (cnt_q >= cfg_i.start) && ({1'b0, cnt_q} <= act_end);
  assign pos_o   = act_o ? (cnt_q - cfg_i.start) : '0;
  assign cnt_o   = cnt_q;

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cfg_i.total);
  // R3
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_tg_pkg::*;
#(
  parameter int CFG_AW = 4,
  parameter int CFG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [CNT_W-1:0]  x_o,
  output logic [CNT_W-1:0]  y_o,
  output logic              req_o,
  output logic              blank_o
);
  localparam int N_AX = 2;

  axis_cfg_t        cfg [N_AX];
  logic             run, pol, frame_end, load, first_q, black, act_all;
  act_mode_e        mode;
  logic [N_AX-1:0]  en, wrap, sync, act;
  logic [CNT_W-1:0] cnt [N_AX];
  logic [CNT_W-1:0] pos [N_AX];

  assign frame_end = wrap[N_AX-1];
  assign load      = !run || frame_end;

  lcd_tg_regs #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .load_i(load), .run_o(run), .cfg_o(cfg), .pol_o(pol), .mode_o(mode)
  );

  for (genvar g = 0; g < N_AX; g++) begin : g_ax
    if (g == 0) begin : g_first
      assign en[g] = run;
    end else begin : g_next
      assign en[g] = run && wrap[g-1];
    end
    lcd_tg_axis u_axis (
      .clk_i, .rst_ni, .clr_i(!run), .en_i(en[g]), .cfg_i(cfg[g]),
      .cnt_o(cnt[g]), .wrap_o(wrap[g]), .sync_o(sync[g]), .act_o(act[g]),
      .pos_o(pos[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        first_q <= 1'b1;
    else if (!run)      first_q <= 1'b1;
    else if (frame_end) first_q <= 1'b0;
  end

  assign black   = first_q && (mode == MODE_BLACK1);
  assign act_all = run && (&act);
  assign hsync_o = run && sync[0];
  assign vsync_o = run && sync[1];
  assign de_o    = pol ? act_all : !act_all;
  assign x_o     = act_all ? pos[0] : '0;
  assign y_o     = act_all ? pos[1] : '0;
  assign req_o   = act_all && !black;
  assign blank_o = act_all && black;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!hsync_o && !vsync_o && !req_o && !blank_o));
  // R8
  req_blank_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && blank_o));
  // R9
  start_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> (cnt[0] == '0 && cnt[1] == '0));
  // R8
  blank_only_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && frame_end) |=> !blank_o);
endmodule

// File: tb/lcd_sync_gen_tb.sv
module lcd_sync_gen_tb;
  import lcd_tg_pkg::*;

  typedef struct {
    bit hs, vs, de, req, blk;
    int x, y;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        we = 0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        hsync, vsync, de, req, blank;
  logic [CNT_W-1:0] x, y;

  int total = 0, bad = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  lcd_sync_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .x_o(x), .y_o(y), .req_o(req), .blank_o(blank)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    we = 1; addr = 4'(a); wdata = 16'(d);
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic set_timing(int ht, int hsw, int hst, int hsz,
                            int vt, int vsw, int vst, int vsz);
    wr(0, ht); wr(1, hsw); wr(2, hst); wr(3, hsz);
    wr(4, vt); wr(5, vsw); wr(6, vst); wr(7, vsz);
  endtask

  // driver side of the scoreboard: one expected item per pixel clock
  task automatic push_frame(int ht, int hsw, int hst, int hsz,
                            int vt, int vsw, int vst, int vsz, bit pol, bit blk);
    for (int v = 0; v <= vt; v++)
      for (int h = 0; h <= ht; h++) begin
        exp_t e;
        bit a;
        a = (h >= hst) && (h <= hst + hsz) && (v >= vst) && (v <= vst + vsz);
        e.hs = h < hsw; e.vs = v < vsw;
        e.de = pol ? a : !a;
        e.x = a ? h - hst : 0; e.y = a ? v - vst : 0;
        e.req = a && !blk; e.blk = a && blk;
        q.push_back(e);
      end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R2 hsync", hsync, e.hs);
      chk("R3 vsync", vsync, e.vs);
      chk("R4/R5 de", de, e.de);
      chk("R6 x", int'(x), e.x);
      chk("R6 y", int'(y), e.y);
      chk("R7 req", req, e.req);
      chk("R8 blank", blank, e.blk);
    end
  end

  task automatic chk_idle(bit de_idle, string tag);
    @(negedge clk);
    chk({tag, " hsync"}, hsync, 0);
    chk({tag, " vsync"}, vsync, 0);
    chk({tag, " de"}, de, de_idle);
    chk({tag, " x"}, int'(x), 0);
    chk({tag, " y"}, int'(y), 0);
    chk({tag, " req"}, req, 0);
    chk({tag, " blank"}, blank, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    chk_idle(0, "R1 reset");
    #1 rst_n = 1;
    chk_idle(0, "R1 after reset");

    // timing A while stopped; mode 2 = black first frame
    set_timing(9, 2, 3, 3, 5, 1, 2, 1);
    wr(9, 4);
    wr(10, 2);
    chk_idle(0, "R1 stopped");
    wr(8, 1);
    // R9: pixel (0,0) follows the run write; R8 first frame black
    push_frame(9, 2, 3, 3, 5, 1, 2, 1, 1, 1);
    push_frame(9, 2, 3, 3, 5, 1, 2, 1, 1, 0);
    // R10: timing B and polarity 0 (R5) written during frame 2 show in frame 3
    push_frame(7, 1, 2, 4, 4, 2, 1, 2, 0, 0);
    repeat (70) @(posedge clk);
    set_timing(7, 1, 2, 4, 4, 2, 1, 2);
    wr(9, 0);
    wait (q.size() == 0);
    wr(8, 0);
    // R9 stop; R1 idle with active-low DE sits high
    chk_idle(1, "R9 stop");
    chk_idle(1, "R1 stopped low pol");

    // R8: mode 1 never blanks, even the first frame
    wr(10, 1);
    wr(8, 1);
    push_frame(7, 1, 2, 4, 4, 2, 1, 2, 0, 0);
    push_frame(7, 1, 2, 4, 4, 2, 1, 2, 0, 0);
    wait (q.size() == 0);
    wr(8, 0);
    chk_idle(1, "R9 stop again");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule